// File: doc/BRIEF.md
# Paged DMA Address Generator

This block is the address and length datapath of a single DMA channel. Software programs an 8-bit page, a 16-bit starting offset and a 16-bit transfer count through a byte-wide load port. Each accepted transfer strobe then produces one registered 24-bit physical address, paired with a one-cycle acknowledge. Once that acknowledge ends, the offset advances and the remaining count drops by one.

The page never changes during a run, so the offset wraps inside its window and does not carry into the page. A mode input picks byte transfers or word transfers. In word mode the offset sits one bit higher in the address, bit 0 is held at zero, and the top page bit falls away. The programmed count is one less than the number of transfers. The last transfer raises terminal count alongside its acknowledge. After that the channel refuses strobes until software loads a new count.

Top module: `paged_dma_addr_gen`

## Requirements
- R1: After reset, xfer_ack, tc and phys_addr are all zero, and the channel is disarmed, so a strobe gives no acknowledge.
- R2: In byte mode (word_mode=0), phys_addr[23:16] is the page and phys_addr[15:0] is the current offset.
- R3: In word mode (word_mode=1), phys_addr[0] is 0, phys_addr[16:1] is the offset and phys_addr[23:17] is page bits 6:0. Page bit 7 has no effect.
- R4: After each acknowledged transfer, the offset steps by one. From 16'hFFFF it wraps to 16'h0000, and the page bits stay unchanged.
- R5: In word mode the wrap takes the address from {page[6:0],17'h1FFFE} to {page[6:0],17'h00000}, which is a 128K-byte window.
- R6: A programmed count of N gives exactly N+1 acknowledges. tc is 1 on the last of them and only there.
- R7: After a transfer with tc, strobes get no acknowledge until the high byte of the count is written.
- R8: A strobe sampled on a rising edge raises xfer_ack for exactly the next cycle. A strobe seen while xfer_ack is high is ignored. phys_addr changes only when a strobe is accepted.
- R9: Writes use wr_sel 0 for the page (whole byte), 1 for the offset and 2 for the count. wr_sel 3 does nothing. Offset and count writes share one byte pointer. A write goes to the low byte when the pointer is 0 and to the high byte when it is 1, and each such write toggles the pointer. ptr_clr forces the pointer to 0, and a write in the same cycle then goes to the low byte.
- R10: A write that lands in the cycle the offset or count advances replaces only its addressed byte of the advanced value. A count high-byte write in the tc advance cycle keeps the channel armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 page, 1 offset, 2 count, 3 none |
| wr_data | input | 8 | Write byte |
| ptr_clr | input | 1 | Clear the shared byte pointer |
| word_mode | input | 1 | 1 = word transfers, 0 = byte transfers |
| xfer_req | input | 1 | Transfer strobe |
| xfer_ack | output | 1 | One-cycle transfer acknowledge |
| tc | output | 1 | Terminal count, valid with xfer_ack |
| phys_addr | output | 24 | Registered physical address |

## Verification
Two functions can fall in the same clock edge: the post-acknowledge advance of offset and count, and a software register write. The bench provokes the clash by driving a write in the very cycle that xfer_ack is visible. It does this once on the offset low byte with ptr_clr asserted, and once on the count high byte during a terminal-count acknowledge. The results are judged only through later strobes. The next address must show the advanced offset with the written byte overlaid. The channel must still accept a strobe, now without tc.

// File: rtl/paged_dma_addr_gen.sv
module paged_dma_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [OFF_W/2-1:0]      wr_data,
  input  logic                    ptr_clr,
  input  logic                    word_mode,
  input  logic                    xfer_req,
  output logic                    xfer_ack,
  output logic                    tc,
  output logic [PAGE_W+OFF_W-1:0] phys_addr
);
  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int HALF   = OFF_W / 2;
  localparam logic [1:0] SEL_PAGE = 2'd0;
  localparam logic [1:0] SEL_OFF  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q, cnt_q, off_step, cnt_step;
  logic              hi_q, armed_q, ack_q, tc_q;
  logic [ADDR_W-1:0] addr_q, addr_form;

  wire wr_page = wr_en && (wr_sel == SEL_PAGE);
  wire wr_off  = wr_en && (wr_sel == SEL_OFF);
  wire wr_cnt  = wr_en && (wr_sel == SEL_CNT);
  wire eff_hi  = hi_q & ~ptr_clr;
  wire accept  = xfer_req & armed_q & ~ack_q;

  function automatic logic [OFF_W-1:0] put_byte(input logic [OFF_W-1:0] v,
                                                input logic hi,
                                                input logic [HALF-1:0] b);
    logic [OFF_W-1:0] r;
    r = v;
    if (hi) r[OFF_W-1:HALF] = b;
    else    r[HALF-1:0]     = b;
    return r;
  endfunction

  assign off_step  = ack_q ? off_q + 1'b1 : off_q;
  assign cnt_step  = ack_q ? cnt_q - 1'b1 : cnt_q;
  assign addr_form = word_mode ? {page_q[PAGE_W-2:0], off_q, 1'b0}
                               : {page_q, off_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
      tc_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (wr_page) page_q <= wr_data[PAGE_W-1:0];
      off_q <= wr_off ? put_byte(off_step, eff_hi, wr_data) : off_step;
      cnt_q <= wr_cnt ? put_byte(cnt_step, eff_hi, wr_data) : cnt_step;
      hi_q  <= (wr_off | wr_cnt) ? ~eff_hi : eff_hi;
      if (wr_cnt && eff_hi)  armed_q <= 1'b1;
      else if (ack_q && tc_q) armed_q <= 1'b0;
      ack_q <= accept;
      tc_q  <= accept && (cnt_q == '0);
      if (accept) addr_q <= addr_form;
    end
  end

  assign xfer_ack  = ack_q;
  assign tc        = tc_q;
  assign phys_addr = addr_q;
endmodule

module paged_dma_addr_gen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_mode,
  input logic              xfer_req,
  input logic              xfer_ack,
  input logic              tc,
  input logic [ADDR_W-1:0] phys_addr
);
  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);
  // R8
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_ack) |-> $past(xfer_req));
  // R6
  tc_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> xfer_ack);
  // R3
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && $past(word_mode)) |-> (phys_addr[0] == 1'b0));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ack && !$past(xfer_req)) |-> $stable(phys_addr));
endmodule

bind paged_dma_addr_gen paged_dma_addr_gen_chk #(.ADDR_W(PAGE_W + OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .xfer_req(xfer_req),
  .xfer_ack(xfer_ack), .tc(tc), .phys_addr(phys_addr));

// File: tb/test_paged_dma_addr_gen.sv
module test_paged_dma_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, ptr_clr = 0, word_mode = 0, xfer_req = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic xfer_ack, tc;
  logic [23:0] phys_addr;

  int checks = 0, errors = 0;
  logic [24:0] exp_q[$];
  string tag_q[$];

  paged_dma_addr_gen i_paged_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_clr(ptr_clr), .word_mode(word_mode), .xfer_req(xfer_req),
    .xfer_ack(xfer_ack), .tc(tc), .phys_addr(phys_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pops expected items as acknowledges appear
  always @(negedge clk) begin
    if (rst_n && xfer_ack) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected ack", {7'd0, tc, phys_addr}, 32'h0);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({tc, phys_addr} == e, t, {7'd0, tc, phys_addr}, {7'd0, e});
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic clr = 0);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; ptr_clr = clr;
    @(negedge clk);
    wr_en = 0; ptr_clr = 0;
  endtask

  task automatic load16(input logic [1:0] sel, input logic [15:0] v);
    wr(sel, v[7:0], 1'b1);
    wr(sel, v[15:8]);
  endtask

  task automatic strobe(input bit acc, input logic [23:0] a, input logic t, input string tag, input int hold = 1);
    if (acc) begin exp_q.push_back({t, a}); tag_q.push_back(tag); end
    @(negedge clk);
    xfer_req = 1;
    repeat (hold) @(negedge clk);
    xfer_req = 0;
    if (!acc) check(xfer_ack == 0, tag, {31'd0, xfer_ack}, 32'h0);
    @(negedge clk);
  endtask

  // strobe, then write in the ack (advance) cycle
  task automatic strobe_wr(input logic [23:0] a, input logic t, input string tag,
                           input logic [1:0] sel, input logic [7:0] d, input logic clr);
    exp_q.push_back({t, a}); tag_q.push_back(tag);
    @(negedge clk);
    xfer_req = 1;
    @(negedge clk);
    xfer_req = 0;
    wr_en = 1; wr_sel = sel; wr_data = d; ptr_clr = clr;
    @(negedge clk);
    wr_en = 0; ptr_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(xfer_ack == 0 && tc == 0 && phys_addr == 0, "R1 reset outputs",
          {7'd0, tc, phys_addr}, 32'h0);
    rst_n = 1;
    strobe(0, 0, 0, "R1 disarmed strobe");

    // R2 R4 R6 byte mode, count 2 -> three transfers
    wr(2'd0, 8'h12);
    load16(2'd1, 16'h3456);
    load16(2'd2, 16'h0002);
    strobe(1, 24'h123456, 0, "R2 first byte addr");
    strobe(1, 24'h123457, 0, "R4 step");
    strobe(1, 24'h123458, 1, "R6 last with tc");
    // R7 locked after tc
    strobe(0, 0, 0, "R7 strobe after tc");
    wr(2'd3, 8'hFF);
    strobe(0, 0, 0, "R9 sel3 no effect, R7 still locked");
    load16(2'd2, 16'h0000);
    strobe(1, 24'h123459, 1, "R6 count 0 one transfer, R7 rearm");

    // R4 byte wrap, page untouched
    load16(2'd1, 16'hFFFE);
    load16(2'd2, 16'h0002);
    strobe(1, 24'h12FFFE, 0, "R4 pre-wrap");
    strobe(1, 24'h12FFFF, 0, "R4 max offset");
    strobe(1, 24'h120000, 1, "R4 wrap keeps page");

    // R3 R5 word mode, page bit 7 dropped
    word_mode = 1;
    wr(2'd0, 8'hA5);
    load16(2'd1, 16'hFFFF);
    load16(2'd2, 16'h0001);
    strobe(1, 24'h4BFFFE, 0, "R3 word addr");
    strobe(1, 24'h4A0000, 1, "R5 word wrap");
    word_mode = 0;

    // R8 strobe held two cycles -> one ack
    wr(2'd0, 8'h01);
    load16(2'd1, 16'h0100);
    load16(2'd2, 16'h0001);
    strobe(1, 24'h010100, 0, "R8 held strobe single ack", 2);
    strobe(1, 24'h010101, 1, "R8 next strobe");

    // R9 byte pointer
    wr(2'd1, 8'h11, 1'b1);
    wr(2'd1, 8'h22, 1'b1);
    wr(2'd1, 8'h33);
    load16(2'd2, 16'h0000);
    strobe(1, 24'h013322, 1, "R9 pointer clear and toggle");

    // R10 offset low-byte write during advance
    wr(2'd0, 8'h00);
    load16(2'd1, 16'h12FF);
    load16(2'd2, 16'h0001);
    strobe_wr(24'h0012FF, 0, "R10 first", 2'd1, 8'h55, 1'b1);
    strobe(1, 24'h001355, 1, "R10 offset overlay on advanced value");

    // R10 count high-byte write in tc advance cycle keeps armed
    load16(2'd1, 16'h2000);
    load16(2'd2, 16'h0000);
    wr(2'd1, 8'h40);
    strobe_wr(24'h002040, 1, "R10 tc transfer", 2'd2, 8'h00, 1'b0);
    strobe(1, 24'h002041, 0, "R10 stays armed, count 00FF");
    load16(2'd2, 16'h0000);
    strobe(1, 24'h002042, 1, "R6 reload after overlap");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all expected acks seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule